// File: doc/BRIEF.md
# Receive Buffer Flush Timeout Timer

This block decides when bytes that are sitting in a receive buffer should go to the host, even though there are not enough of them to fill a packet. It watches the buffer fill level and a strobe that marks each byte written into the buffer. When data has been waiting, with no new byte arriving, for a programmable number of milliseconds, it emits a single-cycle flush request. The transfer logic answers with a flush acknowledge.

The timeout is held in an 8-bit register and counts in whole milliseconds, from 1 to 255. After reset it holds 16. A write of zero is stored as 1. By default the millisecond tick comes from dividing the system clock by a parameter. A parameter can instead select an external tick input. With the internal divider, the divider is cleared every time the timer restarts, so the delay from the last restart to the request is exact. Each new byte restarts the count, and so does each acknowledged flush. An empty buffer holds the timer idle.

Top module: `rxflush_timer`

## Requirements
- R1: After reset `flush_req_o` is low and the timeout register holds 16 ms. With no configuration write, a byte write into an empty buffer leads to a request 16 × CLK_PER_MS cycles later.
- R2: A byte write is sampled at clock edge E while the fill level is nonzero. If nothing else happens, `flush_req_o` goes high right after edge E + T × CLK_PER_MS, where T is the stored timeout in ms.
- R3: A byte write while data is pending restarts the full timeout from that write. No request comes from the earlier write.
- R4: No request is raised while the fill level is zero. If the level falls to zero before expiry, the pending timeout is cancelled.
- R5: `flush_req_o` is high for exactly one cycle per expiry. No further request follows until a byte write or a flush acknowledge.
- R6: A flush acknowledge restarts the timer. If data is still pending, the next request comes T × CLK_PER_MS cycles after the acknowledge edge.
- R7: Writing 0 to the timeout register stores 1 ms.
- R8: The largest timeout, 255 ms, is honoured in full.
- R9: A timeout write applies in 1 ms steps. After writing 3, a byte write leads to a request 3 × CLK_PER_MS cycles later.
- R10: The fill-level input spans the full buffer depth. A level of BUF_DEPTH (384 by default) counts as pending data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick_i | input | 1 | External 1 ms tick, used only when USE_EXT_TICK = 1 |
| cfg_wr_i | input | 1 | Write strobe for the timeout register |
| cfg_timeout_i | input | TO_W | Timeout value in ms (0 is stored as 1) |
| buf_level_i | input | LVL_W | Receive buffer fill level in bytes |
| byte_wr_i | input | 1 | One cycle per byte written into the buffer |
| flush_ack_i | input | 1 | Flush completed by the transfer logic |
| flush_req_o | output | 1 | One-cycle flush request |

## Verification
The timer is driven with a single isolated byte write under several timeouts: the default, a small programmed value, zero and the maximum. This separates a correct millisecond scale and stored value from off-by-one errors in the divider or the compare. A second write before expiry shows whether the count restarts or merely continues. Draining the buffer before expiry shows whether the timeout is cancelled or is only suppressed at the output. An acknowledge while data is still pending shows that the timer re-arms from the acknowledge edge. A full-depth fill level exposes a level input that is too narrow.

// File: rtl/rxft_pkg.sv
package rxft_pkg;

   // Timer phases: no data, counting milliseconds, request issued and waiting.
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_COUNT = 2'd1,
      PH_WAIT  = 2'd2
   } rxft_phase_e;

   // A zero timeout is meaningless; store the shortest legal value instead.
   function automatic logic [7:0] clamp_timeout(input logic [7:0] raw);
      return (raw == 8'd0) ? 8'd1 : raw;
   endfunction

endpackage

// File: rtl/rxft_ms_tick.sv
module rxft_ms_tick #(
   parameter int unsigned CLK_PER_MS   = 48000,
   parameter bit          USE_EXT_TICK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic ext_tick_i,
   output logic tick_o
);

   if (CLK_PER_MS < 2) begin : g_bad_div
      $error("rxft_ms_tick: CLK_PER_MS must be at least 2");
   end

   if (USE_EXT_TICK) begin : g_ext
      // Tick supplied from outside; granularity is one tick period.
      assign tick_o = run_i & ext_tick_i;
   end else begin : g_div
      localparam int unsigned PRE_W = $clog2(CLK_PER_MS);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

      logic             unused_ext;
      logic [PRE_W-1:0] pre_q;

      assign unused_ext = ext_tick_i;

      // Divider is held at zero while the timer is not counting, so every
      // restart yields an exact millisecond boundary.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
         end else if (!run_i) begin
            pre_q <= '0;
         end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end

      assign tick_o = run_i & (pre_q == PRE_LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o) else $error("tick on consecutive cycles"); // R2
   end

endmodule

// File: rtl/rxft_timeout_reg.sv
module rxft_timeout_reg
   import rxft_pkg::*;
#(
   parameter int unsigned TO_W       = 8,
   parameter int unsigned DEFAULT_TO = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [TO_W-1:0] data_i,
   output logic [TO_W-1:0] timeout_o
);

   if (TO_W != 8) begin : g_bad_width
      $error("rxft_timeout_reg: timeout field is 8 bits wide");
   end
   if (DEFAULT_TO < 1 || DEFAULT_TO > 255) begin : g_bad_default
      $error("rxft_timeout_reg: DEFAULT_TO out of 1..255");
   end

   logic [TO_W-1:0] to_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_q <= TO_W'(DEFAULT_TO);
      end else if (wr_i) begin
         to_q <= clamp_timeout(data_i);
      end
   end

   assign timeout_o = to_q;

   AST_TO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      to_q != '0) else $error("stored timeout is zero"); // R7

   AST_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_i) |-> $stable(to_q)) else $error("timeout changed without write"); // R9

endmodule

// File: rtl/rxft_ms_counter.sv
module rxft_ms_counter
   import rxft_pkg::*;
#(
   parameter int unsigned TO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pending_i,
   input  logic            restart_i,
   input  logic            tick_i,
   input  logic [TO_W-1:0] timeout_i,
   output logic            run_o,
   output logic            flush_req_o
);

   rxft_phase_e     phase_q;
   logic [TO_W-1:0] ms_q;
   logic            req_q;
   logic [TO_W:0]   ms_next;
   logic            expire;

   assign ms_next = {1'b0, ms_q} + 1'b1;
   // >= so that a timeout lowered mid-count still expires on the next tick
   assign expire  = tick_i && (ms_next >= {1'b0, timeout_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         ms_q    <= '0;
         req_q   <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (!pending_i) begin
            // Empty buffer: nothing to send, drop any count in progress
            phase_q <= PH_IDLE;
            ms_q    <= '0;
         end else if (restart_i) begin
            phase_q <= PH_COUNT;
            ms_q    <= '0;
         end else begin
            unique case (phase_q)
               PH_IDLE: begin
                  phase_q <= PH_COUNT;
                  ms_q    <= '0;
               end
               PH_COUNT: begin
                  if (expire) begin
                     req_q   <= 1'b1;
                     phase_q <= PH_WAIT;
                     ms_q    <= '0;
                  end else if (tick_i) begin
                     ms_q <= ms_next[TO_W-1:0];
                  end
               end
               PH_WAIT: begin
                  ms_q <= '0;
               end
               default: begin
                  phase_q <= PH_IDLE;
                  ms_q    <= '0;
               end
            endcase
         end
      end
   end

   assign run_o       = pending_i && !restart_i && (phase_q == PH_COUNT);
   assign flush_req_o = req_q;

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req_o |=> !flush_req_o) else $error("request longer than one cycle"); // R5

   AST_NO_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req_o |-> $past(pending_i)) else $error("request with empty buffer"); // R4

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(restart_i && pending_i) |-> (ms_q == '0 && !flush_req_o)) else $error("restart did not clear"); // R3

   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_WAIT) |=> !flush_req_o) else $error("second request while waiting"); // R6

endmodule

// File: rtl/rxflush_timer.sv
module rxflush_timer
   import rxft_pkg::*;
#(
   parameter int unsigned CLK_PER_MS   = 48000,
   parameter bit          USE_EXT_TICK = 1'b0,
   parameter int unsigned TO_W         = 8,
   parameter int unsigned DEFAULT_TO   = 16,
   parameter int unsigned BUF_DEPTH    = 384,
   localparam int unsigned LVL_W       = $clog2(BUF_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_tick_i,
   input  logic             cfg_wr_i,
   input  logic [TO_W-1:0]  cfg_timeout_i,
   input  logic [LVL_W-1:0] buf_level_i,
   input  logic             byte_wr_i,
   input  logic             flush_ack_i,
   output logic             flush_req_o
);

   if (BUF_DEPTH < 1) begin : g_bad_depth
      $error("rxflush_timer: BUF_DEPTH must be positive");
   end

   logic            pending;
   logic            restart;
   logic            run;
   logic            tick;
   logic [TO_W-1:0] timeout;

   assign pending = (buf_level_i != '0);
   assign restart = byte_wr_i | flush_ack_i;

   rxft_timeout_reg #(
      .TO_W       (TO_W),
      .DEFAULT_TO (DEFAULT_TO)
   ) u_to_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (cfg_wr_i),
      .data_i    (cfg_timeout_i),
      .timeout_o (timeout)
   );

   rxft_ms_tick #(
      .CLK_PER_MS   (CLK_PER_MS),
      .USE_EXT_TICK (USE_EXT_TICK)
   ) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run),
      .ext_tick_i (ext_tick_i),
      .tick_o     (tick)
   );

   rxft_ms_counter #(
      .TO_W (TO_W)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .pending_i   (pending),
      .restart_i   (restart),
      .tick_i      (tick),
      .timeout_i   (timeout),
      .run_o       (run),
      .flush_req_o (flush_req_o)
   );

   AST_FULL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_level_i == LVL_W'(BUF_DEPTH)) |-> pending) else $error("full level not pending"); // R10

endmodule

// File: tb/rxflush_timer_bench.sv
module rxflush_timer_bench;

   localparam int N     = 20;
   localparam int LVL_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ext_tick_i = 1'b0;
   logic             cfg_wr_i = 1'b0;
   logic [7:0]       cfg_timeout_i = '0;
   logic [LVL_W-1:0] buf_level_i = '0;
   logic             byte_wr_i = 1'b0;
   logic             flush_ack_i = 1'b0;
   logic             flush_req_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   rxflush_timer #(
      .CLK_PER_MS   (N),
      .USE_EXT_TICK (1'b0),
      .TO_W         (8),
      .DEFAULT_TO   (16),
      .BUF_DEPTH    (384)
   ) u_rxflush_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .ext_tick_i    (ext_tick_i),
      .cfg_wr_i      (cfg_wr_i),
      .cfg_timeout_i (cfg_timeout_i),
      .buf_level_i   (buf_level_i),
      .byte_wr_i     (byte_wr_i),
      .flush_ack_i   (flush_ack_i),
      .flush_req_o   (flush_req_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_timeout(input logic [7:0] v);
      @(negedge clk);
      buf_level_i   = '0;
      cfg_wr_i      = 1'b1;
      cfg_timeout_i = v;
      @(negedge clk);
      cfg_wr_i = 1'b0;
   endtask

   task automatic write_byte(input int level);
      @(negedge clk);
      byte_wr_i   = 1'b1;
      buf_level_i = LVL_W'(level);
      @(negedge clk);
      byte_wr_i = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk);
      flush_ack_i = 1'b1;
      @(negedge clk);
      flush_ack_i = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      buf_level_i = '0;
      @(negedge clk);
   endtask

   // first: cycle index of first high sample (-1 if none); highs: count
   task automatic measure(input int window, output int first, output int highs);
      first = -1;
      highs = 0;
      for (int k = 1; k <= window; k++) begin
         @(negedge clk);
         if (flush_req_o) begin
            highs++;
            if (first < 0) first = k;
         end
      end
   endtask

   task automatic t_reset_default();
      int f, h;
      check("R1 reset req low", int'(flush_req_o), 0);
      write_byte(1);
      measure(16 * N + 30, f, h);
      check("R1 default 16ms delay", f, 16 * N);
      check("R1 single pulse", h, 1);
      drain();
   endtask

   task automatic t_program();
      int f, h;
      set_timeout(8'd3);
      write_byte(2);
      measure(3 * N + 5, f, h);
      check("R9 programmed 3ms delay", f, 3 * N);
      check("R2 request at T*N", h, 1);
      measure(200, f, h);
      check("R5 no repeat without ack", h, 0);
      drain();
   endtask

   task automatic t_restart();
      int f, h;
      set_timeout(8'd5);
      write_byte(1);
      measure(50, f, h);
      check("R3 none before restart", h, 0);
      write_byte(2);
      measure(5 * N + 20, f, h);
      check("R3 delay from second write", f, 5 * N);
      check("R3 one request", h, 1);
      drain();
   endtask

   task automatic t_empty();
      int f, h;
      set_timeout(8'd3);
      measure(300, f, h);
      check("R4 empty buffer no request", h, 0);
      write_byte(1);
      measure(40, f, h);
      check("R4 none before drain", h, 0);
      drain();
      measure(200, f, h);
      check("R4 drain cancels timeout", h, 0);
   endtask

   task automatic t_ack();
      int f, h;
      set_timeout(8'd2);
      write_byte(4);
      measure(2 * N + 5, f, h);
      check("R6 first request", f, 2 * N);
      ack();
      measure(2 * N + 20, f, h);
      check("R6 request after ack", f, 2 * N);
      check("R5 after-ack pulse width", h, 1);
      drain();
   endtask

   task automatic t_zero();
      int f, h;
      set_timeout(8'd0);
      write_byte(1);
      measure(N + 20, f, h);
      check("R7 zero treated as 1ms", f, N);
      drain();
   endtask

   task automatic t_max();
      int f, h;
      set_timeout(8'd255);
      write_byte(1);
      measure(255 * N + 30, f, h);
      check("R8 255ms delay", f, 255 * N);
      check("R8 single pulse", h, 1);
      drain();
   endtask

   task automatic t_full();
      int f, h;
      set_timeout(8'd1);
      write_byte(384);
      measure(N + 10, f, h);
      check("R10 full level pending", f, N);
      drain();
   endtask

   initial begin
      #100000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_default();
      t_program();
      t_restart();
      t_empty();
      t_ack();
      t_zero();
      t_max();
      t_full();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule